// File: doc/BRIEF.md
# Per-Master Domain Permission Checker

This block sits behind an address translator and decides whether a translated access may proceed. Each access comes in with the number of the bus master that issued it, its direction (read or write), its untranslated address and the page table entry the translator found. Four bits of that entry pick one of sixteen permission domains. Every domain stores, for each master, one bit that denies reads and one bit that denies writes. The answer comes back one cycle later as a deny flag.

When an access is refused, the block sets the status bit of the master that issued it. For that master it also keeps the address and the entry word of the first refused access, until software clears the status bit. An interrupt line is driven from the status bits that software has enabled. Software reaches the domain table, the interrupt enable, clear and status registers and the per-master error registers through a simple word-wide register port. The domain registers hold two domains each.

Top module: `perm_domain_checker`

## Requirements
- R1: For a request taken on a clock edge, `resp_valid` is high for exactly the following cycle and `resp_deny` carries the verdict. The domain index is bits 7:4 of `req_pte`, and no other bit of the entry affects the verdict.
- R2: Domain d is programmed through the register at offset 0x0B0 + 4*(d/2). Bit (d mod 2)*16 + 2*m denies reads by master m in that domain, and the bit just above it denies writes. A read of the register returns the stored bits, and every bit outside those fields reads as 0.
- R3: An access is denied exactly when the deny bit for its direction, its master and its domain is set. Otherwise it is allowed.
- R4: Domain 0 is fixed: it allows reads and denies writes for every master. Register writes to its half of offset 0x0B0 are ignored, so that half always reads back 0x0AAA for six masters.
- R5: A denied access from master m sets bit m of the status register at offset 0x108. Writes to offset 0x108 have no effect.
- R6: Writing a 1 to bit m of the clear register at offset 0x104 clears status bit m. If a fault from master m arrives in the same cycle, the bit stays set.
- R7: The error address register of master m is at 0x110 + 4*m, and its error entry register is at 0x150 + 4*m. They capture the address and the entry word of a fault only while status bit m is clear, or while it is being cleared in that same cycle. Otherwise they keep the first fault.
- R8: `irq` is high exactly when some status bit is set whose bit is also set in the enable register at offset 0x100.
- R9: A request whose master number is six or more is denied and does not change any status bit.
- R10: After reset the status, enable and error registers are zero, domains 1 to 15 allow every access, and `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An access is offered for checking this cycle |
| req_master | input | 3 | Number of the issuing master |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| req_addr | input | 32 | Untranslated address of the access |
| req_pte | input | 32 | Page table entry; bits 7:4 give the domain |
| resp_valid | output | 1 | Verdict for the request of the previous cycle |
| resp_deny | output | 1 | The access is refused |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr`, combinational |
| irq | output | 1 | Interrupt: an enabled status bit is set |

## Verification
The bench looks for the places where the packed layout can go wrong. One case is a domain in the odd half of a register, where a shift error would make one master's read permission guard another master's write. Another is domain 0, where a writable implementation would take in the all-ones pattern and let writes through. The error registers are tested with a second fault before the clear: a design that overwrites them would report the later address. A clear and a fault are also sent in the same cycle: a design that gives the clear priority would lose the new fault. Finally, an out-of-range master number is sent, which a naive index would map onto some master's permission bit and status bit.

// File: rtl/perm_chk_pkg.sv
package perm_chk_pkg;

   localparam int unsigned PTE_W        = 32;
   localparam int unsigned DOM_IDX_LSB  = 4;
   localparam int unsigned DOM_IDX_W    = 4;
   localparam int unsigned HALF_BITS    = 16;

   localparam int unsigned OFS_DOM_BASE = 'h0B0;
   localparam int unsigned OFS_IRQ_EN   = 'h100;
   localparam int unsigned OFS_IRQ_CLR  = 'h104;
   localparam int unsigned OFS_IRQ_STAT = 'h108;
   localparam int unsigned OFS_ERR_ADDR = 'h110;
   localparam int unsigned OFS_ERR_DATA = 'h150;

   // bit position of a deny flag inside a packed domain register
   function automatic int unsigned deny_bit(int unsigned dom, int unsigned mst, bit is_wr);
      return (dom % 2) * HALF_BITS + 2 * mst + (is_wr ? 1 : 0);
   endfunction

endpackage

// File: rtl/perm_domain_table.sv
module perm_domain_table
   import perm_chk_pkg::*;
#(
   parameter int unsigned NUM_MASTERS    = 6,
   parameter int unsigned NUM_DOMAINS    = 16,
   parameter bit          DOM0_READ_ONLY = 1'b1,
   parameter int unsigned IDX_W          = 3
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   wr_en,
   input  logic [IDX_W-1:0]                       wr_idx,
   input  logic [31:0]                            wr_data,
   output logic [NUM_DOMAINS-1:0][NUM_MASTERS-1:0] rd_deny_o,
   output logic [NUM_DOMAINS-1:0][NUM_MASTERS-1:0] wr_deny_o
);

   for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
      for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
         if (d == 0 && DOM0_READ_ONLY) begin : g_fixed
            assign rd_deny_o[d][m] = 1'b0;
            assign wr_deny_o[d][m] = 1'b1;
         end else begin : g_prog
            logic rd_q, wr_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  rd_q <= 1'b0;
                  wr_q <= 1'b0;
               end else if (wr_en && wr_idx == IDX_W'(d / 2)) begin
                  rd_q <= wr_data[deny_bit(d, m, 1'b0)];
                  wr_q <= wr_data[deny_bit(d, m, 1'b1)];
               end
            end
            assign rd_deny_o[d][m] = rd_q;
            assign wr_deny_o[d][m] = wr_q;

            assert_table_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_en && wr_idx == IDX_W'(d / 2)) |=>
                  (rd_deny_o[d][m] == $past(wr_data[deny_bit(d, m, 1'b0)])));
         end
      end
   end

endmodule

// File: rtl/perm_decide.sv
module perm_decide
   import perm_chk_pkg::*;
#(
   parameter int unsigned NUM_MASTERS = 6,
   parameter int unsigned NUM_DOMAINS = 16,
   parameter int unsigned MID_W       = 3
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   req_valid,
   input  logic [MID_W-1:0]                       req_master,
   input  logic                                   req_write,
   input  logic [PTE_W-1:0]                       req_pte,
   input  logic [NUM_DOMAINS-1:0][NUM_MASTERS-1:0] rd_deny_i,
   input  logic [NUM_DOMAINS-1:0][NUM_MASTERS-1:0] wr_deny_i,
   output logic                                   resp_valid_o,
   output logic                                   resp_deny_o,
   output logic [NUM_MASTERS-1:0]                 fault_o
);

   logic [DOM_IDX_W-1:0] dom;
   logic                 mst_ok;
   logic                 deny;

   assign dom    = req_pte[DOM_IDX_LSB +: DOM_IDX_W];
   assign mst_ok = (32'(req_master) < NUM_MASTERS);

   always_comb begin
      deny = 1'b1;
      if (mst_ok && 32'(dom) < NUM_DOMAINS) begin
         deny = req_write ? wr_deny_i[dom][req_master] : rd_deny_i[dom][req_master];
      end
   end

   for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_fault
      assign fault_o[m] = req_valid && deny && (req_master == MID_W'(m));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid_o <= 1'b0;
         resp_deny_o  <= 1'b0;
      end else begin
         resp_valid_o <= req_valid;
         resp_deny_o  <= req_valid && deny;
      end
   end

   assert_resp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid_o);

   assert_bad_master_denied_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mst_ok) |=> resp_deny_o);

   assert_fault_matches_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|fault_o) |=> (resp_valid_o && resp_deny_o));

endmodule

// File: rtl/perm_fault_log.sv
module perm_fault_log #(
   parameter int unsigned AW    = 32,
   parameter int unsigned PTE_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fault_i,
   input  logic             clr_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [PTE_W-1:0] pte_i,
   output logic             status_o,
   output logic [AW-1:0]    addr_o,
   output logic [PTE_W-1:0] data_o
);

   logic capture;
   assign capture = fault_i && (!status_o || clr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_o <= 1'b0;
         addr_o   <= '0;
         data_o   <= '0;
      end else begin
         status_o <= (status_o && !clr_i) || fault_i;
         if (capture) begin
            addr_o <= addr_i;
            data_o <= pte_i;
         end
      end
   end

   assert_fault_sets_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fault_i |=> status_o);

   assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o && !clr_i) |=> status_o);

   assert_first_fault_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o && !clr_i) |=> ($stable(addr_o) && $stable(data_o)));

endmodule

// File: rtl/perm_domain_checker.sv
module perm_domain_checker
   import perm_chk_pkg::*;
#(
   parameter int unsigned NUM_MASTERS    = 6,
   parameter int unsigned NUM_DOMAINS    = 16,
   parameter int unsigned AW             = 32,
   parameter int unsigned CFG_AW         = 12,
   parameter bit          DOM0_READ_ONLY = 1'b1,
   parameter int unsigned MID_W          = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [MID_W-1:0]  req_master,
   input  logic              req_write,
   input  logic [AW-1:0]     req_addr,
   input  logic [31:0]       req_pte,
   output logic              resp_valid,
   output logic              resp_deny,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              irq
);

   localparam int unsigned REG_CNT = NUM_DOMAINS / 2;
   localparam int unsigned IDX_W   = (REG_CNT > 1) ? $clog2(REG_CNT) : 1;
   localparam int unsigned DOM_END = OFS_DOM_BASE + 4 * REG_CNT;

   if (NUM_MASTERS < 1 || NUM_MASTERS > 8) begin : g_bad_masters
      $error("NUM_MASTERS must lie in 1..8");
   end
   if (NUM_DOMAINS < 2 || NUM_DOMAINS > 16 || (NUM_DOMAINS % 2) != 0) begin : g_bad_domains
      $error("NUM_DOMAINS must be even and lie in 2..16");
   end
   if (AW > 32 || (1 << MID_W) < NUM_MASTERS) begin : g_bad_widths
      $error("AW must not exceed 32 and MID_W must cover every master");
   end

   logic [NUM_DOMAINS-1:0][NUM_MASTERS-1:0] rd_deny, wr_deny;
   logic [NUM_MASTERS-1:0] fault, clr_vec, status, irq_en_q;
   logic [NUM_MASTERS-1:0][AW-1:0] err_addr;
   logic [NUM_MASTERS-1:0][31:0]   err_data;
   logic             dom_we;
   logic [IDX_W-1:0] dom_idx;

   always_comb begin
      dom_we  = cfg_we && cfg_addr[1:0] == 2'b00 &&
                32'(cfg_addr) >= OFS_DOM_BASE && 32'(cfg_addr) < DOM_END;
      dom_idx = IDX_W'((32'(cfg_addr) - OFS_DOM_BASE) >> 2);
   end

   assign clr_vec = (cfg_we && cfg_addr == CFG_AW'(OFS_IRQ_CLR)) ? cfg_wdata[NUM_MASTERS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en_q <= '0;
      end else if (cfg_we && cfg_addr == CFG_AW'(OFS_IRQ_EN)) begin
         irq_en_q <= cfg_wdata[NUM_MASTERS-1:0];
      end
   end

   perm_domain_table #(
      .NUM_MASTERS(NUM_MASTERS), .NUM_DOMAINS(NUM_DOMAINS),
      .DOM0_READ_ONLY(DOM0_READ_ONLY), .IDX_W(IDX_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .wr_en(dom_we), .wr_idx(dom_idx), .wr_data(cfg_wdata),
      .rd_deny_o(rd_deny), .wr_deny_o(wr_deny)
   );

   perm_decide #(
      .NUM_MASTERS(NUM_MASTERS), .NUM_DOMAINS(NUM_DOMAINS), .MID_W(MID_W)
   ) u_decide (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_master(req_master),
      .req_write(req_write), .req_pte(req_pte), .rd_deny_i(rd_deny), .wr_deny_i(wr_deny),
      .resp_valid_o(resp_valid), .resp_deny_o(resp_deny), .fault_o(fault)
   );

   for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_log
      perm_fault_log #(.AW(AW), .PTE_W(32)) u_log (
         .clk(clk), .rst_n(rst_n), .fault_i(fault[m]), .clr_i(clr_vec[m]),
         .addr_i(req_addr), .pte_i(req_pte),
         .status_o(status[m]), .addr_o(err_addr[m]), .data_o(err_data[m])
      );
   end

   assign irq = |(status & irq_en_q);

   always_comb begin
      cfg_rdata = '0;
      for (int r = 0; r < REG_CNT; r++) begin
         if (cfg_addr == CFG_AW'(OFS_DOM_BASE + 4 * r)) begin
            for (int m = 0; m < NUM_MASTERS; m++) begin
               cfg_rdata[2 * m]                 = rd_deny[2 * r][m];
               cfg_rdata[2 * m + 1]             = wr_deny[2 * r][m];
               cfg_rdata[HALF_BITS + 2 * m]     = rd_deny[2 * r + 1][m];
               cfg_rdata[HALF_BITS + 2 * m + 1] = wr_deny[2 * r + 1][m];
            end
         end
      end
      if (cfg_addr == CFG_AW'(OFS_IRQ_EN))   cfg_rdata[NUM_MASTERS-1:0] = irq_en_q;
      if (cfg_addr == CFG_AW'(OFS_IRQ_STAT)) cfg_rdata[NUM_MASTERS-1:0] = status;
      for (int m = 0; m < NUM_MASTERS; m++) begin
         if (cfg_addr == CFG_AW'(OFS_ERR_ADDR + 4 * m)) cfg_rdata[AW-1:0] = err_addr[m];
         if (cfg_addr == CFG_AW'(OFS_ERR_DATA + 4 * m)) cfg_rdata = err_data[m];
      end
   end

   if (DOM0_READ_ONLY) begin : g_dom0_chk
      assert_dom0_write_denied_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_write && req_pte[DOM_IDX_LSB +: DOM_IDX_W] == '0) |=> resp_deny);
   end

   assert_bad_master_no_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && 32'(req_master) >= NUM_MASTERS && clr_vec == '0) |=> $stable(status));

endmodule

// File: tb/perm_domain_checker_tb.sv
`timescale 1ns/1ps
module perm_domain_checker_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_master = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_pte = '0;
   logic        resp_valid, resp_deny;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   perm_domain_checker u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_master(req_master),
      .req_write(req_write), .req_addr(req_addr), .req_pte(req_pte),
      .resp_valid(resp_valid), .resp_deny(resp_deny), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq)
   );

   // vector: [8:6] master, [5] write, [4:1] domain, [0] expected deny
   localparam logic [8:0] VEC [16] = '{
      {3'd0, 1'b0, 4'd0,  1'b0}, {3'd3, 1'b1, 4'd0,  1'b1},
      {3'd1, 1'b0, 4'd1,  1'b1}, {3'd4, 1'b1, 4'd1,  1'b1},
      {3'd2, 1'b0, 4'd2,  1'b0}, {3'd2, 1'b1, 4'd2,  1'b1},
      {3'd5, 1'b0, 4'd3,  1'b1}, {3'd5, 1'b1, 4'd3,  1'b0},
      {3'd0, 1'b0, 4'd4,  1'b0}, {3'd0, 1'b1, 4'd4,  1'b0},
      {3'd2, 1'b0, 4'd5,  1'b1}, {3'd2, 1'b1, 4'd5,  1'b0},
      {3'd5, 1'b1, 4'd5,  1'b1}, {3'd5, 1'b0, 4'd5,  1'b0},
      {3'd1, 1'b0, 4'd5,  1'b0}, {3'd3, 1'b1, 4'd15, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic access(input logic [2:0] m, input logic wr, input logic [31:0] a,
                         input logic [31:0] pte, output logic v, output logic dn);
      @(negedge clk);
      req_valid = 1'b1; req_master = m; req_write = wr; req_addr = a; req_pte = pte;
      @(negedge clk);
      req_valid = 1'b0;
      v = resp_valid; dn = resp_deny;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic v, dn;
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 resp_valid", {31'd0, resp_valid}, 32'd0);
      check("R10 irq", {31'd0, irq}, 32'd0);
      cfg_read(12'h108, rd); check("R10 status", rd, 32'd0);
      rst_n = 1'b1;
      cfg_read(12'h100, rd); check("R10 enable", rd, 32'd0);
      cfg_read(12'h0B4, rd); check("R10 domains 2/3 open", rd, 32'd0);
      cfg_read(12'h0B0, rd); check("R4 domain0 fixed at reset", rd, 32'h0000_0AAA);

      // R2 programming and readback; R4 domain 0 half ignores writes
      cfg_write(12'h0B0, 32'hFFFF_FFFF);
      cfg_write(12'h0B4, 32'h0555_0AAA);
      cfg_write(12'h0B8, 32'h0810_0000);
      cfg_read(12'h0B0, rd); check("R4 R2 readback 0xB0", rd, 32'h0FFF_0AAA);
      cfg_read(12'h0B4, rd); check("R2 readback 0xB4", rd, 32'h0555_0AAA);
      cfg_read(12'h0B8, rd); check("R2 readback 0xB8", rd, 32'h0810_0000);

      // R3 R1: table of verdicts, odd bits of the entry set to show they are ignored
      for (int i = 0; i < 16; i++) begin
         access(VEC[i][8:6], VEC[i][5], 32'h1000_0000 + 32'(i),
                {20'hA5A5A, 4'hF, VEC[i][4:1], 4'hF}, v, dn);
         check($sformatf("R1 valid vector %0d", i), {31'd0, v}, 32'd1);
         check($sformatf("R3 verdict vector %0d", i), {31'd0, dn}, {31'd0, VEC[i][0]});
      end

      cfg_write(12'h104, 32'h0000_003F);
      cfg_read(12'h108, rd); check("R6 clear all", rd, 32'd0);
      cfg_write(12'h100, 32'h0000_003F);
      cfg_read(12'h100, rd); check("R8 enable readback", rd, 32'h3F);
      check("R8 irq low with empty status", {31'd0, irq}, 32'd0);

      // first fault latch
      access(3'd4, 1'b1, 32'hDEAD_0040, 32'h1234_5F12, v, dn);
      check("R3 master4 write domain1", {31'd0, dn}, 32'd1);
      cfg_read(12'h108, rd); check("R5 status bit4", rd, 32'h10);
      check("R8 irq raised", {31'd0, irq}, 32'd1);
      cfg_read(12'h120, rd); check("R7 err addr m4", rd, 32'hDEAD_0040);
      cfg_read(12'h160, rd); check("R7 err data m4", rd, 32'h1234_5F12);
      access(3'd4, 1'b0, 32'h0BAD_F00C, 32'h7777_7710, v, dn);
      cfg_read(12'h120, rd); check("R7 first fault kept addr", rd, 32'hDEAD_0040);
      cfg_read(12'h160, rd); check("R7 first fault kept data", rd, 32'h1234_5F12);
      cfg_write(12'h108, 32'h0000_0000);
      cfg_read(12'h108, rd); check("R5 status write ignored", rd, 32'h10);
      cfg_write(12'h104, 32'h0000_0010);
      cfg_read(12'h108, rd); check("R6 clear bit4", rd, 32'd0);
      check("R8 irq dropped", {31'd0, irq}, 32'd0);
      access(3'd4, 1'b0, 32'h0BAD_F00C, 32'h7777_7710, v, dn);
      cfg_read(12'h120, rd); check("R7 recapture after clear", rd, 32'h0BAD_F00C);

      // clear and fault in the same cycle
      @(negedge clk);
      req_valid = 1'b1; req_master = 3'd4; req_write = 1'b1;
      req_addr = 32'hCAFE_0100; req_pte = 32'h0000_0012;
      cfg_we = 1'b1; cfg_addr = 12'h104; cfg_wdata = 32'h10;
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0;
      cfg_read(12'h108, rd); check("R6 fault beats clear", rd, 32'h10);
      cfg_read(12'h120, rd); check("R7 capture during clear", rd, 32'hCAFE_0100);

      // enable masking
      cfg_write(12'h100, 32'h0000_0001);
      check("R8 irq masked", {31'd0, irq}, 32'd0);
      access(3'd0, 1'b1, 32'h0000_2000, 32'h0000_0002, v, dn);
      check("R4 domain0 write denied", {31'd0, dn}, 32'd1);
      cfg_read(12'h108, rd); check("R5 status m0 and m4", rd, 32'h11);
      check("R8 irq from enabled m0", {31'd0, irq}, 32'd1);

      // out-of-range master
      access(3'd6, 1'b0, 32'h0000_3000, 32'h0000_00F0, v, dn);
      check("R9 master6 denied", {31'd0, dn}, 32'd1);
      cfg_read(12'h108, rd); check("R9 status unchanged", rd, 32'h11);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule